// File: doc/BRIEF.md
# I2C Controller FIFO and Threshold Interrupt Unit

This unit sits between the register port and the bus engine of an I2C controller. It owns two byte FIFOs: software fills the transmit FIFO and the bus engine drains it, while the bus engine fills the receive FIFO and software drains it. From the FIFO fill levels and from illegal accesses it builds a set of interrupt causes. A single combined interrupt line is driven from those causes after masking.

Software programs a control word that holds the per-direction enables and the two trigger levels. It also programs an interrupt enable mask and a trailing-timeout count. It reads a FIFO status word and an interrupt status word. Level-based causes follow the FIFO fill state from cycle to cycle. Error causes and the trailing cause are sticky, and software clears each one by writing a one to its bit. A cause that is raised in the same cycle as its clear stays set, so an event is never lost.

Top module: `i2c_fifo_irq_unit`

## Requirements
- R1: After reset both FIFOs are empty, the FIFO status word reads 0x0100_0100, the interrupt status reads 0, `irq` is low, both directions are disabled and the trailing count is 15.
- R2: Control word encoding: bit 0 enables RX, bit 1 enables TX, bits 10:4 hold the RX trigger and bits 22:16 hold the TX trigger. FIFO status encoding: TX level in bits 6:0, TX full at 7, TX empty at 8, RX level in bits 22:16, RX full at 23 and RX empty at 24. Both FIFOs return bytes in the order they were written.
- R3: Interrupt status bit 0 (TX almost-empty) is 1 exactly while TX is enabled and the TX level is less than or equal to the TX trigger.
- R4: Interrupt status bit 1 (RX almost-full) is 1 exactly while RX is enabled and the RX level is greater than or equal to the RX trigger.
- R5: A software write to a full TX FIFO sets sticky bit 3 (TX overrun). An engine push into a full RX FIFO sets sticky bit 5 (RX overrun). In both cases the byte is dropped and the level stays at the depth.
- R6: An engine pop from an empty TX FIFO sets sticky bit 2 (TX underrun). A software read of an empty RX FIFO sets sticky bit 4 (RX underrun).
- R7: A write on `ist_clr_we` clears each sticky bit (2 to 6) whose `cfg_wdata` bit is 1 and leaves the other bits alone. Live bits 0 and 1 are not affected. A cause raised in the same cycle as its clear stays set.
- R8: Sticky bit 6 (trailing) is set when the RX FIFO is enabled, holds at least one byte and fewer than the RX trigger, and no byte has been pushed for the programmed count of cycles (`trail_we` loads the count from `cfg_wdata[7:0]`). It is set on the count-th clock edge after the edge that took the last push. A count of 0 disables the trailing cause.
- R9: `irq` is a register that, on each clock edge, takes the OR of every interrupt status bit ANDed with the enable bit at the same position (`ien_we` loads the enables from `cfg_wdata[6:0]`). It therefore follows the status by one cycle.
- R10: A FIFO whose enable is 0 is flushed to empty on the next clock edge. Pushes and pops to it are ignored and raise no error cause.
- R11: A byte popped by software (`sw_rx_re`) or by the engine (`eng_tx_pop`) appears on `sw_rx_byte` or `eng_tx_byte` on the clock edge that performs the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wdata | input | 32 | Write data shared by all register strobes and by the software TX write |
| ctl_we | input | 1 | Load the control word |
| ien_we | input | 1 | Load the interrupt enable mask |
| ist_clr_we | input | 1 | Write-one-to-clear of the sticky interrupt status bits |
| trail_we | input | 1 | Load the trailing count |
| sw_tx_we | input | 1 | Software pushes `cfg_wdata[7:0]` into the TX FIFO |
| sw_rx_re | input | 1 | Software pops the RX FIFO |
| sw_rx_byte | output | 8 | Byte most recently popped by software |
| eng_rx_push | input | 1 | Bus engine pushes a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_tx_pop | input | 1 | Bus engine pops a byte to transmit |
| eng_tx_byte | output | 8 | Byte most recently popped by the engine |
| fifo_status | output | 32 | FIFO level, full and empty flags |
| irq_status | output | 7 | Interrupt cause bits |
| irq | output | 1 | Combined, masked interrupt |

## Verification
The threshold causes are tested with trigger values that leave the level below, at and above the trigger. This separates an inclusive comparison from a strict one in both directions. The FIFOs are filled to the brim and one byte beyond, and drained one byte past empty, from both the software side and the engine side. This shows that dropped bytes never reach the scoreboard and that each error cause is tied to its own direction. The trailing cause is checked one cycle before and exactly at its deadline, and again with a zero count. Write-one-to-clear is tested both on its own and in the same cycle as a new error, which tells clear priority apart from set priority.

// File: rtl/i2c_fq_pkg.sv
package i2c_fq_pkg;
  localparam int STAT_W       = 7;
  localparam int B_TXAE       = 0;
  localparam int B_RXAF       = 1;
  localparam int B_TXUR       = 2;
  localparam int B_TXOR       = 3;
  localparam int B_RXUR       = 4;
  localparam int B_RXOR       = 5;
  localparam int B_TRAIL      = 6;
  localparam logic [STAT_W-1:0] STICKY_MASK = 7'b111_1100;
  localparam logic [STAT_W-1:0] LIVE_MASK   = 7'b000_0011;

  localparam int TRIG_W       = 7;
  localparam int C_RXEN       = 0;
  localparam int C_TXEN       = 1;
  localparam int C_RXTRIG_LSB = 4;
  localparam int C_TXTRIG_LSB = 16;

  localparam int S_TXLVL_LSB  = 0;
  localparam int S_TXFULL     = 7;
  localparam int S_TXEMPTY    = 8;
  localparam int S_RXLVL_LSB  = 16;
  localparam int S_RXFULL     = 23;
  localparam int S_RXEMPTY    = 24;

  typedef struct packed {
    logic              rx_en;
    logic              tx_en;
    logic [TRIG_W-1:0] rx_trig;
    logic [TRIG_W-1:0] tx_trig;
  } fifo_ctl_t;

  function automatic fifo_ctl_t decode_ctl(input logic [31:0] w);
    fifo_ctl_t c;
    c.rx_en   = w[C_RXEN];
    c.tx_en   = w[C_TXEN];
    c.rx_trig = w[C_RXTRIG_LSB +: TRIG_W];
    c.tx_trig = w[C_TXTRIG_LSB +: TRIG_W];
    return c;
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          push_drop,
  output logic          pop_drop
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign push_ok   = push && !full && !flush;
  assign pop_ok    = pop && !empty && !flush;
  assign push_drop = push && full && !flush;
  assign pop_drop  = pop && empty && !flush;
  assign level     = count;

  // storage and read register kept reset-free so a block RAM can hold them
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
    if (pop_ok)  pop_data    <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  initial begin
    a_r2_pow2_depth: assert ((1 << AW) == DEPTH)
      else $error("byte_fifo depth must be a power of two");
  end

  a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));

  a_r2_no_phantom: assert property (@(posedge clk) disable iff (rst)
    (empty && !push) |=> empty);
endmodule

// File: rtl/trail_timer.sv
module trail_timer #(
  parameter int CW     = 5,
  parameter int TRIG_W = 7,
  parameter int TW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic [CW-1:0]     level,
  input  logic [TRIG_W-1:0] rx_trig,
  input  logic              push,
  input  logic [TW-1:0]     limit,
  output logic              fire
);
  logic [TW-1:0] cnt;
  logic          partial;

  assign partial = rx_en && (level != '0) && (TRIG_W'(level) < rx_trig);

  always_ff @(posedge clk) begin
    if (rst || !partial || push) cnt <= '0;
    else if (cnt != limit)       cnt <= cnt + TW'(1);
  end

  assign fire = partial && !push && (limit != '0) && (cnt == limit - TW'(1));

  a_r8_count_saturates: assert property (@(posedge clk) disable iff (rst)
    (limit != '0) |-> (cnt <= limit));
endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import i2c_fq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] live_vec,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_mask,
  input  logic              en_we,
  input  logic [STAT_W-1:0] en_data,
  output logic [STAT_W-1:0] stat,
  output logic              irq
);
  logic [STAT_W-1:0] sticky, en_q, clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;
  assign stat    = (sticky & STICKY_MASK) | (live_vec & LIVE_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky <= '0;
      en_q   <= '0;
      irq    <= 1'b0;
    end else begin
      sticky <= ((sticky & ~clr_eff) | set_vec) & STICKY_MASK;
      if (en_we) en_q <= en_data;
      irq <= |(stat & en_q);
    end
  end

  a_r7_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((sticky & $past(sticky)) == $past(sticky)));

  a_r7_clear_effect: assert property (@(posedge clk) disable iff (rst)
    (clr_we && set_vec == '0) |=> ((sticky & $past(clr_mask)) == '0));

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq);
endmodule

// File: rtl/i2c_fifo_irq_unit.sv
module i2c_fifo_irq_unit
  import i2c_fq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int TRAIL_W = 8,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       cfg_wdata,
  input  logic              ctl_we,
  input  logic              ien_we,
  input  logic              ist_clr_we,
  input  logic              trail_we,
  input  logic              sw_tx_we,
  input  logic              sw_rx_re,
  output logic [7:0]        sw_rx_byte,
  input  logic              eng_rx_push,
  input  logic [7:0]        eng_rx_byte,
  input  logic              eng_tx_pop,
  output logic [7:0]        eng_tx_byte,
  output logic [31:0]       fifo_status,
  output logic [STAT_W-1:0] irq_status,
  output logic              irq
);
  fifo_ctl_t          ctl;
  logic [TRAIL_W-1:0] trail_lim;

  logic [CW-1:0] tx_lvl, rx_lvl;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_pdrop, tx_qdrop, rx_pdrop, rx_qdrop;
  logic trail_fire;
  logic [STAT_W-1:0] live_vec, set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= '0;
      trail_lim <= TRAIL_W'(15);
    end else begin
      if (ctl_we)   ctl       <= decode_ctl(cfg_wdata);
      if (trail_we) trail_lim <= cfg_wdata[TRAIL_W-1:0];
    end
  end

  byte_fifo #(.DEPTH(DEPTH), .DW(8)) i_tx_fifo (
    .clk(clk), .rst(rst), .flush(!ctl.tx_en),
    .push(sw_tx_we), .push_data(cfg_wdata[7:0]),
    .pop(eng_tx_pop), .pop_data(eng_tx_byte),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty),
    .push_drop(tx_pdrop), .pop_drop(tx_qdrop)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(8)) i_rx_fifo (
    .clk(clk), .rst(rst), .flush(!ctl.rx_en),
    .push(eng_rx_push), .push_data(eng_rx_byte),
    .pop(sw_rx_re), .pop_data(sw_rx_byte),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty),
    .push_drop(rx_pdrop), .pop_drop(rx_qdrop)
  );

  trail_timer #(.CW(CW), .TRIG_W(TRIG_W), .TW(TRAIL_W)) i_trail (
    .clk(clk), .rst(rst), .rx_en(ctl.rx_en), .level(rx_lvl),
    .rx_trig(ctl.rx_trig), .push(eng_rx_push && ctl.rx_en),
    .limit(trail_lim), .fire(trail_fire)
  );

  always_comb begin
    live_vec          = '0;
    live_vec[B_TXAE]  = ctl.tx_en && (TRIG_W'(tx_lvl) <= ctl.tx_trig);
    live_vec[B_RXAF]  = ctl.rx_en && (TRIG_W'(rx_lvl) >= ctl.rx_trig);
    set_vec           = '0;
    set_vec[B_TXUR]   = tx_qdrop;
    set_vec[B_TXOR]   = tx_pdrop;
    set_vec[B_RXUR]   = rx_qdrop;
    set_vec[B_RXOR]   = rx_pdrop;
    set_vec[B_TRAIL]  = trail_fire;
  end

  irq_flags i_flags (
    .clk(clk), .rst(rst), .live_vec(live_vec), .set_vec(set_vec),
    .clr_we(ist_clr_we), .clr_mask(cfg_wdata[STAT_W-1:0]),
    .en_we(ien_we), .en_data(cfg_wdata[STAT_W-1:0]),
    .stat(irq_status), .irq(irq)
  );

  always_comb begin
    fifo_status                           = '0;
    fifo_status[S_TXLVL_LSB +: TRIG_W]    = TRIG_W'(tx_lvl);
    fifo_status[S_TXFULL]                 = tx_full;
    fifo_status[S_TXEMPTY]                = tx_empty;
    fifo_status[S_RXLVL_LSB +: TRIG_W]    = TRIG_W'(rx_lvl);
    fifo_status[S_RXFULL]                 = rx_full;
    fifo_status[S_RXEMPTY]                = rx_empty;
  end

  a_r10_flush_empty: assert property (@(posedge clk) disable iff (rst)
    (!ctl.tx_en && !ctl.rx_en) |=> (tx_lvl == '0 && rx_lvl == '0));

  a_r8_trail_partial: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_status[B_TRAIL]) |-> $past(ctl.rx_en && rx_lvl != '0));

  a_r5_overrun_full: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_status[B_TXOR]) |-> $past(tx_full));
endmodule

// File: tb/test_i2c_fifo_irq_unit.sv
module test_i2c_fifo_irq_unit;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_wdata = '0;
  logic        ctl_we = 0, ien_we = 0, ist_clr_we = 0, trail_we = 0;
  logic        sw_tx_we = 0, sw_rx_re = 0, eng_rx_push = 0, eng_tx_pop = 0;
  logic [7:0]  eng_rx_byte = '0;
  logic [7:0]  sw_rx_byte, eng_tx_byte;
  logic [31:0] fifo_status;
  logic [6:0]  irq_status;
  logic        irq;

  always #2 clk = ~clk;

  i2c_fifo_irq_unit #(.DEPTH(DEPTH)) i_i2c_fifo_irq_unit (
    .clk(clk), .rst(rst), .cfg_wdata(cfg_wdata), .ctl_we(ctl_we),
    .ien_we(ien_we), .ist_clr_we(ist_clr_we), .trail_we(trail_we),
    .sw_tx_we(sw_tx_we), .sw_rx_re(sw_rx_re), .sw_rx_byte(sw_rx_byte),
    .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte),
    .eng_tx_pop(eng_tx_pop), .eng_tx_byte(eng_tx_byte),
    .fifo_status(fifo_status), .irq_status(irq_status), .irq(irq)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] tx_q[$], rx_q[$];
  logic tx_expect = 0, rx_expect = 0, tx_pend = 0, rx_pend = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // scoreboard monitor: compare popped bytes one edge after the pop
  always @(posedge clk) begin
    tx_pend <= tx_expect;
    rx_pend <= rx_expect;
  end
  always @(negedge clk) begin
    if (tx_pend) begin
      if (tx_q.size() == 0) chk("R11 tx scoreboard underflow", 1, 0);
      else chk("R11 R2 tx byte order", {24'h0, eng_tx_byte}, {24'h0, tx_q.pop_front()});
    end
    if (rx_pend) begin
      if (rx_q.size() == 0) chk("R11 rx scoreboard underflow", 1, 0);
      else chk("R11 R2 rx byte order", {24'h0, sw_rx_byte}, {24'h0, rx_q.pop_front()});
    end
  end

  task automatic cyc(); @(negedge clk); endtask

  task automatic wr_ctl(logic [31:0] v);
    cfg_wdata = v; ctl_we = 1; cyc(); ctl_we = 0;
  endtask
  task automatic wr_ien(logic [31:0] v);
    cfg_wdata = v; ien_we = 1; cyc(); ien_we = 0;
  endtask
  task automatic w1c(logic [31:0] v);
    cfg_wdata = v; ist_clr_we = 1; cyc(); ist_clr_we = 0;
  endtask
  task automatic wr_trail(logic [31:0] v);
    cfg_wdata = v; trail_we = 1; cyc(); trail_we = 0;
  endtask
  task automatic sw_push(logic [7:0] b, bit keep);
    cfg_wdata = {24'h0, b}; sw_tx_we = 1;
    if (keep) tx_q.push_back(b);
    cyc(); sw_tx_we = 0;
  endtask
  task automatic eng_pop(bit expect_data);
    eng_tx_pop = 1; tx_expect = expect_data; cyc(); eng_tx_pop = 0; tx_expect = 0;
  endtask
  task automatic eng_push(logic [7:0] b, bit keep);
    eng_rx_byte = b; eng_rx_push = 1;
    if (keep) rx_q.push_back(b);
    cyc(); eng_rx_push = 0;
  endtask
  task automatic sw_read(bit expect_data);
    sw_rx_re = 1; rx_expect = expect_data; cyc(); sw_rx_re = 0; rx_expect = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R1 reset state
    chk("R1 fifo status", fifo_status, 32'h0100_0100);
    chk("R1 irq status", {25'h0, irq_status}, 0);
    chk("R1 irq low", {31'h0, irq}, 0);

    // enable both, RX trigger 4, TX trigger 2
    wr_ctl(32'h0002_0043);
    chk("R3 tx almost-empty at level 0", {31'h0, irq_status[0]}, 1);
    chk("R4 rx below trigger", {31'h0, irq_status[1]}, 0);

    sw_push(8'hA1, 1); sw_push(8'hB2, 1); sw_push(8'hC3, 1);
    chk("R2 tx level 3", fifo_status[8:0], 9'h003);
    chk("R3 tx above trigger", {31'h0, irq_status[0]}, 0);

    wr_ien(32'h01);
    eng_pop(1);
    chk("R3 tx level equals trigger", {31'h0, irq_status[0]}, 1);
    eng_pop(1);
    cyc();
    chk("R9 irq follows enabled cause", {31'h0, irq}, 1);
    wr_ien(32'h00);
    cyc();
    chk("R9 irq masked", {31'h0, irq}, 0);

    eng_pop(1);
    eng_pop(0);
    chk("R6 tx underrun", {25'h0, irq_status}, 32'h05);
    w1c(32'h04);
    chk("R7 clear leaves live bit", {25'h0, irq_status}, 32'h01);

    for (int i = 0; i < DEPTH; i++) sw_push(8'(i * 17 + 5), 1);
    sw_push(8'hEE, 0);
    chk("R5 tx full level", fifo_status[8:0], 9'h090);
    chk("R5 tx overrun", {31'h0, irq_status[3]}, 1);
    for (int i = 0; i < DEPTH; i++) eng_pop(1);
    chk("R5 dropped byte absent", fifo_status[8:0], 9'h100);

    w1c(32'h7F);
    chk("R7 clear all sticky", {25'h0, irq_status}, 32'h01);
    eng_push(8'h11, 1); eng_push(8'h22, 1);
    chk("R4 rx level 2 below trigger", {31'h0, irq_status[1]}, 0);
    eng_push(8'h33, 1); eng_push(8'h44, 1);
    chk("R4 rx level equals trigger", {31'h0, irq_status[1]}, 1);
    chk("R2 rx level field", fifo_status[24:16], 9'h004);
    for (int i = 0; i < 4; i++) sw_read(1);
    sw_read(0);
    chk("R6 rx underrun", {31'h0, irq_status[4]}, 1);

    w1c(32'h7F);
    eng_push(8'h5A, 1);
    repeat (14) cyc();
    chk("R8 trailing not yet", {31'h0, irq_status[6]}, 0);
    cyc();
    chk("R8 trailing at deadline", {31'h0, irq_status[6]}, 1);
    sw_read(1);
    wr_trail(32'h0);
    w1c(32'h40);
    eng_push(8'h6B, 1);
    repeat (40) cyc();
    chk("R8 zero count disables", {31'h0, irq_status[6]}, 0);
    sw_read(1);
    wr_trail(32'd15);

    w1c(32'h7F);
    for (int i = 0; i < DEPTH; i++) eng_push(8'(8'hF0 - 8'(i * 3)), 1);
    eng_push(8'h99, 0);
    chk("R5 rx overrun", {31'h0, irq_status[5]}, 1);
    chk("R5 rx full level", fifo_status[24:16], 9'h090);
    for (int i = 0; i < DEPTH; i++) sw_read(1);

    w1c(32'h7F);
    cfg_wdata = 32'h10; ist_clr_we = 1; sw_rx_re = 1;
    cyc();
    ist_clr_we = 0; sw_rx_re = 0;
    chk("R7 set wins over clear", {31'h0, irq_status[4]}, 1);

    w1c(32'h7F);
    sw_push(8'h31, 0); sw_push(8'h32, 0);
    eng_push(8'h41, 0);
    wr_ctl(32'h0);
    cyc();
    chk("R10 flushed when disabled", fifo_status, 32'h0100_0100);
    sw_push(8'h77, 0);
    eng_pop(0);
    sw_read(0);
    chk("R10 access ignored", fifo_status, 32'h0100_0100);
    chk("R10 no error causes", {25'h0, irq_status}, 0);

    cyc();
    chk("R2 scoreboard drained", tx_q.size() + rx_q.size(), 0);
    report();
  end
endmodule